// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Signed Set-Less-Than

This block is a purely combinational arithmetic-logic unit for a 32-bit integer datapath. It is assembled from a chain of one-bit slices. Each slice forms the AND and OR of its operand bits and a full-adder sum, and it can also pass a "less" input straight through to its result bit. A single operation code picks which of these each slice drives out. The code also decides whether the second operand is inverted and whether a carry is injected at the bottom of the ripple chain, so one adder chain serves both addition and subtraction.

Signed set-less-than reuses the subtraction path. The most significant slice forms a set signal from its sum bit and the signed overflow of the chain, and that signal is routed back to the less input of bit 0. Every other slice has its less input tied low. The block also reports a zero flag over the whole result and a signed overflow flag that is only valid for add and subtract. There is no state, clock or reset. Results settle within one combinational path and are meant to be captured by the surrounding pipeline.

Top module: `alu_sliced32`

## Requirements
- R1: Operation code 4'b0000 drives `alu_res` with the bitwise AND of `opnd_a` and `opnd_b`.
- R2: Operation code 4'b0001 drives `alu_res` with the bitwise OR of `opnd_a` and `opnd_b`.
- R3: Operation code 4'b0010 drives `alu_res` with `opnd_a + opnd_b` modulo 2^32.
- R4: Operation code 4'b0110 drives `alu_res` with `opnd_a - opnd_b` modulo 2^32. Bit 2 of the code both inverts the second operand and sets the carry into bit 0.
- R5: Operation code 4'b0111 drives `alu_res[0]` to 1 exactly when `opnd_a` is less than `opnd_b` as two's-complement numbers, and drives `alu_res[31:1]` to 0. The answer is correct even when `opnd_a - opnd_b` overflows.
- R6: `res_zero` is 1 exactly when all 32 bits of `alu_res` are 0, for every operation.
- R7: For add, `ovf_flag` is 1 exactly when both operands have the same sign bit and the sum's sign bit differs from it.
- R8: For subtract, `ovf_flag` is 1 exactly when the operands' sign bits differ and the difference's sign bit differs from that of `opnd_a`.
- R9: For AND, OR and set-less-than, `ovf_flag` is 0 whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| alu_op | input | 4 | Operation code: 0000 AND, 0001 OR, 0010 add, 0110 subtract, 0111 set-less-than |
| alu_res | output | 32 | Result |
| res_zero | output | 1 | High when the result is all zeros |
| ovf_flag | output | 1 | Signed overflow of add or subtract; low otherwise |

## Verification
The hardest case to reach is set-less-than when the internal subtraction overflows. The raw sign of the difference then gives the wrong answer, and only the overflow correction in the top slice puts it right. Random operands seldom land there, so the stimulus crosses every pair from a fixed set of extreme values, among them 0x7FFFFFFF, 0x80000000, 0, 0xFFFFFFFF, 1 and their neighbours. That drives the chain into overflow with both sign combinations for every operation. A long stream of random pairs then covers ordinary carry patterns. Pairs with equal operands make the zero flag rise under subtraction.

// File: rtl/alu_pkg.sv
package alu_pkg;
    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_AND = 4'b0000,
        OP_OR  = 4'b0001,
        OP_ADD = 4'b0010,
        OP_SUB = 4'b0110,
        OP_SLT = 4'b0111
    } alu_op_e;

    // per-slice output selection, taken from the two low code bits
    typedef enum logic [1:0] {
        SEL_AND  = 2'b00,
        SEL_OR   = 2'b01,
        SEL_SUM  = 2'b10,
        SEL_LESS = 2'b11
    } slice_sel_e;
endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import alu_pkg::*;
(
    input  logic       a_bit,
    input  logic       b_bit,
    input  logic       b_flip,
    input  logic       carry_in,
    input  logic       less_in,
    input  slice_sel_e sel,
    output logic       res_bit,
    output logic       sum_bit,
    output logic       carry_out
);
    logic b_eff;

    always_comb begin
        b_eff     = b_bit ^ b_flip;
        sum_bit   = a_bit ^ b_eff ^ carry_in;
        carry_out = (a_bit & b_eff) | (carry_in & (a_bit ^ b_eff));
        unique case (sel)
            SEL_AND:  res_bit = a_bit & b_eff;
            SEL_OR:   res_bit = a_bit | b_eff;
            SEL_SUM:  res_bit = sum_bit;
            SEL_LESS: res_bit = less_in;
            default:  res_bit = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_msb_slice.sv
module alu_msb_slice
    import alu_pkg::*;
(
    input  logic       a_bit,
    input  logic       b_bit,
    input  logic       b_flip,
    input  logic       carry_in,
    input  logic       less_in,
    input  slice_sel_e sel,
    output logic       res_bit,
    output logic       carry_out,
    output logic       set_out,
    output logic       ovf_out
);
    logic sum_w;

    alu_bit_slice u_core (
        .a_bit    (a_bit),
        .b_bit    (b_bit),
        .b_flip   (b_flip),
        .carry_in (carry_in),
        .less_in  (less_in),
        .sel      (sel),
        .res_bit  (res_bit),
        .sum_bit  (sum_w),
        .carry_out(carry_out)
    );

    always_comb begin
        ovf_out = carry_in ^ carry_out;
        set_out = sum_w ^ ovf_out;   // true sign of a-b even on overflow
    end
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] value,
    output logic             is_zero
);
    always_comb is_zero = ~(|value);
endmodule

// File: rtl/alu_sliced32.sv
module alu_sliced32
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [3:0]       alu_op,
    output logic [WIDTH-1:0] alu_res,
    output logic             res_zero,
    output logic             ovf_flag
);
    localparam int MSB = WIDTH - 1;

    logic       carry [WIDTH+1];
    logic       set_msb;
    logic       ovf_raw;
    logic       negate_b;
    logic       arith_op;
    slice_sel_e sel;

    always_comb begin
        negate_b = alu_op[2];
        sel      = slice_sel_e'(alu_op[1:0]);
        arith_op = (alu_op == OP_ADD) || (alu_op == OP_SUB);
    end

    assign carry[0] = negate_b;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        if (i == MSB) begin : g_top
            alu_msb_slice u_slice (
                .a_bit    (opnd_a[i]),
                .b_bit    (opnd_b[i]),
                .b_flip   (negate_b),
                .carry_in (carry[i]),
                .less_in  (1'b0),
                .sel      (sel),
                .res_bit  (alu_res[i]),
                .carry_out(carry[i+1]),
                .set_out  (set_msb),
                .ovf_out  (ovf_raw)
            );
        end else begin : g_low
            logic sum_unused;
            alu_bit_slice u_slice (
                .a_bit    (opnd_a[i]),
                .b_bit    (opnd_b[i]),
                .b_flip   (negate_b),
                .carry_in (carry[i]),
                .less_in  ((i == 0) ? set_msb : 1'b0),
                .sel      (sel),
                .res_bit  (alu_res[i]),
                .sum_bit  (sum_unused),
                .carry_out(carry[i+1])
            );
        end
    end

    alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
        .value  (alu_res),
        .is_zero(res_zero)
    );

    always_comb ovf_flag = ovf_raw & arith_op;

    // ---------------- assertions ----------------
    always_comb begin
        if (!$isunknown({alu_op, opnd_a, opnd_b})) begin
            if (alu_op == OP_AND) AST_AND_RESULT: assert (alu_res == (opnd_a & opnd_b)); // R1
            if (alu_op == OP_OR)  AST_OR_RESULT:  assert (alu_res == (opnd_a | opnd_b)); // R2
            if (alu_op == OP_ADD) AST_ADD_RESULT: assert (alu_res == opnd_a + opnd_b); // R3
            if (alu_op == OP_SUB) AST_SUB_RESULT: assert (alu_res == opnd_a - opnd_b); // R4
            if (alu_op == OP_SLT) AST_SLT_RESULT: assert (alu_res == {{MSB{1'b0}}, ($signed(opnd_a) < $signed(opnd_b))}); // R5
            AST_ZERO_FLAG: assert (res_zero == (alu_res == '0)); // R6
            if (alu_op == OP_ADD) AST_ADD_OVERFLOW: assert (ovf_flag == ((opnd_a[MSB] == opnd_b[MSB]) && (alu_res[MSB] != opnd_a[MSB]))); // R7
            if (alu_op == OP_SUB) AST_SUB_OVERFLOW: assert (ovf_flag == ((opnd_a[MSB] != opnd_b[MSB]) && (alu_res[MSB] != opnd_a[MSB]))); // R8
            if (!arith_op) AST_NO_OVERFLOW: assert (!ovf_flag); // R9
        end
    end
endmodule

// File: tb/tb_alu_sliced32.sv
module tb_alu_sliced32;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic [3:0]   op = 4'b0000;
    logic [W-1:0] res;
    logic         zf;
    logic         vf;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    alu_sliced32 #(.WIDTH(W)) dut (
        .opnd_a  (a),
        .opnd_b  (b),
        .alu_op  (op),
        .alu_res (res),
        .res_zero(zf),
        .ovf_flag(vf)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h", req, op, a, b, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
        logic [W-1:0] er;
        logic         ev;
        string        rq;
        @(negedge clk);
        op = o; a = x; b = y;
        #5;
        ev = 1'b0;
        case (o)
            4'b0000: begin er = x & y; rq = "R1"; end
            4'b0001: begin er = x | y; rq = "R2"; end
            4'b0010: begin
                er = x + y; rq = "R3";
                ev = (x[W-1] == y[W-1]) && (er[W-1] != x[W-1]);
            end
            4'b0110: begin
                er = x - y; rq = "R4";
                ev = (x[W-1] != y[W-1]) && (er[W-1] != x[W-1]);
            end
            default: begin er = {{(W-1){1'b0}}, $signed(x) < $signed(y)}; rq = "R5"; end
        endcase
        check(rq, res, er);
        check("R6", {{(W-1){1'b0}}, zf}, {{(W-1){1'b0}}, (er == '0)});
        if (o == 4'b0010)      check("R7", {{(W-1){1'b0}}, vf}, {{(W-1){1'b0}}, ev});
        else if (o == 4'b0110) check("R8", {{(W-1){1'b0}}, vf}, {{(W-1){1'b0}}, ev});
        else                   check("R9", {{(W-1){1'b0}}, vf}, '0);
    endtask

    logic [W-1:0] corner [10];
    logic [3:0]   ops    [5];

    initial begin
        corner[0] = 32'h0000_0000; corner[1] = 32'hFFFF_FFFF;
        corner[2] = 32'h7FFF_FFFF; corner[3] = 32'h8000_0000;
        corner[4] = 32'h0000_0001; corner[5] = 32'h8000_0001;
        corner[6] = 32'h7FFF_FFFE; corner[7] = 32'hFFFF_FFFE;
        corner[8] = 32'h5555_5555; corner[9] = 32'hAAAA_AAAA;
        ops[0] = 4'b0000; ops[1] = 4'b0001; ops[2] = 4'b0010;
        ops[3] = 4'b0110; ops[4] = 4'b0111;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // all-zero inputs: AND gives zero result and zero flag
        apply(4'b0000, '0, '0);
        // R5 under overflow: most negative vs most positive
        apply(4'b0111, 32'h8000_0000, 32'h7FFF_FFFF);
        apply(4'b0111, 32'h7FFF_FFFF, 32'h8000_0000);
        for (int k = 0; k < 5; k++)
            for (int i = 0; i < 10; i++)
                for (int j = 0; j < 10; j++)
                    apply(ops[k], corner[i], corner[j]);
        for (int n = 0; n < 3000; n++) begin
            logic [W-1:0] x;
            logic [W-1:0] y;
            x = $urandom;
            y = (n % 7 == 0) ? x : $urandom;
            apply(ops[n % 5], x, y);
        end
        done = 1'b1;
    end

    initial begin
        for (int t = 0; t < 150000; t++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule